// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the device side of a three-wire serial link: an active-high select, a serial clock from the host and one data line. It gives a host access to an eight-entry byte register file that lives in a timekeeping core. All three link inputs are brought into the faster system clock domain through synchronizers, and serial clock edges are found there. The data line is split into a data-in pin, a data-out pin and an output-enable pin. The pad ring combines them into a single bidirectional wire.

Every transfer opens with a command byte that picks the direction, the register, or an all-register burst. Data bytes follow it, least significant bit first. The host changes its bits while the clock is low, and the block samples them on the clock rising edge. On reads, the block launches each bit after a clock falling edge.

The core exposes its registers to this block as a flat read bus. It accepts writes through a one-cycle strobe that carries an address and a data byte. The top bit of the last register is a write lock, and this block enforces it.

Top module: `tw_regif`

## Requirements
- R1: After reset, and in every cycle in which the synchronized select is low, the output enable and the write strobe are both low; lowering select ends any transfer.
- R2: The first 8 bits after select rises form a command sent bit 0 first. Bit 0 = 1 requests a read and 0 a write, bits 3:1 hold the register index, and bit 7 must be 1. A command with bit 7 = 0 produces no write and no drive.
- R3: Incoming bits are taken on serial-clock rising edges and bytes are assembled LSB first (the first bit after the command is data bit 0).
- R4: A single-register write stores the 8 bits following the command into the addressed register with exactly one strobe; any further clock pulses in the same transfer are ignored.
- R5: A single-register read launches data bit 0 on the first falling edge after the eighth command bit, LSB first, and keeps resending the same byte for as long as select stays high.
- R6: The command 0xBE (write) or 0xBF (read) moves all eight registers in order starting at index 0, in 72 clock pulses including the command.
- R7: While bit 7 of register 7 is 1, writes to registers 0 to 6 produce no strobe; a single-register write to register 7 is still accepted.
- R8: A burst write never writes register 7; its eighth byte is dropped.
- R9: Any command matching 1001xxx1 is a no-operation: no drive and no strobe for the rest of the transfer.
- R10: A data byte cut short by select going low produces no strobe, and the next transfer works normally.
- R11: The output enable is high only in the data phase of a read, and never during a write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least 8 times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Transfer select from the host, active high |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Data line as seen by the input buffer |
| sdo_o | output | 1 | Data to drive onto the line during a read |
| sdo_oe_o | output | 1 | Output-buffer enable for the data line |
| rd_data_i | input | NREG*DW | Flattened register contents from the core, register i at bits i*DW upward |
| wr_en_o | output | 1 | One-cycle write strobe to the core |
| wr_addr_o | output | 3 | Register index of the write |
| wr_data_o | output | DW | Byte to write |

## Verification
If the bit counter or the command phase is wrong, the error shows within the same byte. The byte that reads back will be rotated, the strobe will come one byte early or late, or the enable will rise during a write. A stale address shows up as the wrong register on the next read-back, or as burst data that is shifted by one index. The lock bit, the test-mode codes and the abort path change only whether a strobe fires, so each one is checked by counting strobes and reading the affected register back in a following transfer.

// File: rtl/tw_pkg.sv
package tw_pkg;
   localparam int TW_DW   = 8;
   localparam int TW_NREG = 8;
   localparam int TW_AW   = 3;

   typedef enum logic [1:0] {
      PH_CMD,
      PH_WR,
      PH_RD,
      PH_SKIP
   } tw_phase_t;

   typedef struct packed {
      logic             ok;
      logic             rd;
      logic             burst;
      logic [TW_AW-1:0] addr;
   } tw_cmd_t;

   // Decode a command byte: bit 7 must be set, 1001xxx1 is reserved (no-op),
   // 1011111x selects the all-register sequence starting at index 0.
   function automatic tw_cmd_t tw_decode(input logic [TW_DW-1:0] c);
      tw_cmd_t d;
      d.rd    = c[0];
      d.burst = (c[7:1] == 7'b1011111);
      d.addr  = d.burst ? '0 : c[3:1];
      d.ok    = c[7] && !((c[7:4] == 4'b1001) && c[0]);
      return d;
   endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tw_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("tw_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/tw_engine.sv
module tw_engine
   import tw_pkg::*;
#(
   parameter int DW   = TW_DW,
   parameter int NREG = TW_NREG,
   parameter int AW   = TW_AW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel,
   input  logic               rise,
   input  logic               fall,
   input  logic               sdi,
   input  logic [NREG*DW-1:0] rd_data_i,
   output logic               sdo,
   output logic               oe,
   output logic               wr_en,
   output logic [AW-1:0]      wr_addr,
   output logic [DW-1:0]      wr_data,
   output logic               burst_o
);
   localparam int            CW   = $clog2(DW);
   localparam logic [CW-1:0] LAST = CW'(DW - 1);
   localparam logic [AW-1:0] TOP  = AW'(NREG - 1);

   tw_phase_t     ph;
   logic [CW-1:0] cnt;
   logic [DW-1:0] sh, lat, nxt, cur, rd_byte;
   logic [AW-1:0] addr;
   logic          burst, wp, allow;
   tw_cmd_t       dec;

   always_comb begin
      nxt     = {sdi, sh[DW-1:1]};
      dec     = tw_decode(nxt);
      rd_byte = rd_data_i[addr*DW +: DW];
      cur     = (cnt == '0) ? rd_byte : lat;
      wp      = rd_data_i[NREG*DW-1];
      allow   = (addr == TOP) ? !burst : !wp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_CMD;
         cnt     <= '0;
         sh      <= '0;
         lat     <= '0;
         addr    <= '0;
         burst   <= 1'b0;
         sdo     <= 1'b0;
         oe      <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (!sel) begin
            ph    <= PH_CMD;
            cnt   <= '0;
            burst <= 1'b0;
            oe    <= 1'b0;
            sdo   <= 1'b0;
         end else begin
            unique case (ph)
               PH_CMD: if (rise) begin
                  sh  <= nxt;
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST) begin
                     addr  <= dec.addr;
                     burst <= dec.burst;
                     ph    <= !dec.ok ? PH_SKIP : (dec.rd ? PH_RD : PH_WR);
                  end
               end
               PH_WR: if (rise) begin
                  sh  <= nxt;
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST) begin
                     wr_en   <= allow;
                     wr_addr <= addr;
                     wr_data <= nxt;
                     if (!burst || addr == TOP) ph <= PH_SKIP;
                     else                       addr <= addr + 1'b1;
                  end
               end
               PH_RD: if (fall) begin
                  sdo <= cur[cnt];
                  oe  <= 1'b1;
                  cnt <= cnt + 1'b1;
                  if (cnt == '0) lat <= rd_byte;
                  if (cnt == LAST && burst) addr <= addr + 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign burst_o = burst;
endmodule

// File: rtl/tw_regif.sv
module tw_regif
   import tw_pkg::*;
#(
   parameter int DW          = TW_DW,
   parameter int NREG        = TW_NREG,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_i,
   input  logic               sck_i,
   input  logic               sdi_i,
   output logic               sdo_o,
   output logic               sdo_oe_o,
   input  logic [NREG*DW-1:0] rd_data_i,
   output logic               wr_en_o,
   output logic [TW_AW-1:0]   wr_addr_o,
   output logic [DW-1:0]      wr_data_o
);
   generate
      if (DW != TW_DW || NREG != TW_NREG) begin : g_bad_geom
         $error("tw_regif: command format fixes DW and NREG at 8");
      end
   endgenerate

   logic [2:0] sync_q;
   logic       sel_s, sck_s, sdi_s, sck_d, sck_rise, sck_fall, burst_s;

   tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sel_i, sck_i, sdi_i}),
      .q     (sync_q)
   );

   assign {sel_s, sck_s, sdi_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign sck_rise = sck_s & ~sck_d;
   assign sck_fall = ~sck_s & sck_d;

   tw_engine #(.DW(DW), .NREG(NREG), .AW(TW_AW)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel_s),
      .rise      (sck_rise),
      .fall      (sck_fall),
      .sdi       (sdi_s),
      .rd_data_i (rd_data_i),
      .sdo       (sdo_o),
      .oe        (sdo_oe_o),
      .wr_en     (wr_en_o),
      .wr_addr   (wr_addr_o),
      .wr_data   (wr_data_o),
      .burst_o   (burst_s)
   );
endmodule

// File: rtl/tw_regif_chk.sv
module tw_regif_chk #(
   parameter int AW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sel_s,
   input logic          burst_s,
   input logic          wp,
   input logic          sdo_oe_o,
   input logic          wr_en_o,
   input logic [AW-1:0] wr_addr_o
);
   localparam logic [AW-1:0] TOP = '1;

   a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_s |=> (!sdo_oe_o && !wr_en_o));

   a_r4_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o);

   a_r7_lock_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && wp) |-> (wr_addr_o == TOP));

   a_r8_burst_spares_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && burst_s) |-> (wr_addr_o != TOP));

   a_r11_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> !sdo_oe_o);
endmodule

bind tw_regif tw_regif_chk #(.AW(tw_pkg::TW_AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel_s     (sel_s),
   .burst_s   (burst_s),
   .wp        (rd_data_i[NREG*DW-1]),
   .sdo_oe_o  (sdo_oe_o),
   .wr_en_o   (wr_en_o),
   .wr_addr_o (wr_addr_o)
);

// File: tb/tb_tw_regif.sv
`timescale 1ns/1ps
module tb_tw_regif;
   localparam int H = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0, sck = 1'b0, sdi = 1'b0;
   logic       sdo_o, sdo_oe_o, wr_en_o;
   logic [2:0] wr_addr_o;
   logic [7:0] wr_data_o;
   logic [63:0] rd_bus;
   logic [7:0] mem [8];
   logic [7:0] expv [8];
   int         nstb = 0;
   int         n_chk = 0, n_fail = 0, oe_bad = 0;
   logic       in_wr = 1'b0;

   always #4 clk = ~clk;

   tw_regif dut (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .sck_i(sck), .sdi_i(sdi),
      .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .rd_data_i(rd_bus),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
   );

   // core model
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) mem[i] <= 8'h00;
      end else if (wr_en_o) begin
         mem[wr_addr_o] <= wr_data_o;
         nstb <= nstb + 1;
      end
   end

   always_comb begin
      for (int i = 0; i < 8; i++) rd_bus[i*8 +: 8] = mem[i];
   end

   always @(negedge clk) if (in_wr && sdo_oe_o) oe_bad++;

   task automatic chk(input logic ok, input string req, input int act, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
      end
   endtask

   task automatic clocks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tbit(input logic b, output logic r, output logic oe);
      sdi = b;
      clocks(H);
      r  = sdo_o;
      oe = sdo_oe_o;
      sck = 1'b1;
      clocks(H);
      sck = 1'b0;
   endtask

   task automatic tx(input logic [7:0] v);
      logic r, oe;
      for (int i = 0; i < 8; i++) tbit(v[i], r, oe);
   endtask

   task automatic rx(output logic [7:0] v, output logic all_oe);
      logic r, oe;
      all_oe = 1'b1;
      for (int i = 0; i < 8; i++) begin
         tbit(1'b0, r, oe);
         v[i] = r;
         all_oe &= oe;
      end
   endtask

   task automatic start_x();
      sel = 1'b1;
      clocks(H);
   endtask

   task automatic stop_x();
      clocks(H);
      sel = 1'b0;
      clocks(2*H);
   endtask

   task automatic wr1(input logic [2:0] a, input logic [7:0] v);
      in_wr = 1'b1;
      start_x(); tx(8'h80 | {4'b0, a, 1'b0}); tx(v); stop_x();
      in_wr = 1'b0;
   endtask

   task automatic rd1(input logic [2:0] a, output logic [7:0] v);
      logic oe;
      start_x(); tx(8'h81 | {4'b0, a, 1'b0}); rx(v, oe); stop_x();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] b1, b2, v;
      logic oe1, oe2;
      int s0;
      for (int i = 0; i < 8; i++) expv[i] = 8'h00;
      clocks(10);
      chk(!sdo_oe_o && !wr_en_o, "R1 reset quiet", {sdo_oe_o, wr_en_o}, 0);
      rst_n = 1'b1;
      clocks(4);

      // sweep single writes and reads (R2 R3 R4 R5)
      for (int p = 0; p < 3; p++) begin
         for (int a = 0; a < 7; a++) begin
            v = 8'((a * 53 + p * 91 + 7) & 255);
            s0 = nstb;
            wr1(3'(a), v);
            expv[a] = v;
            chk(nstb - s0 == 1, "R4 one strobe", nstb - s0, 1);
            start_x(); tx(8'h81 | 8'(a << 1));
            rx(b1, oe1); rx(b2, oe2);
            stop_x();
            chk(b1 == expv[a], "R3 R5 read LSB first", b1, expv[a]);
            chk(b2 == b1, "R5 repeated byte", b2, b1);
            chk(oe1 && oe2, "R11 enable in read data", {oe1, oe2}, 3);
            chk(!sdo_oe_o, "R1 released after select low", sdo_oe_o, 0);
         end
      end

      // extra clocks after a write (R4)
      s0 = nstb;
      in_wr = 1'b1;
      start_x(); tx(8'h84); tx(8'h5A); tx(8'hFF); tx(8'h00); stop_x();
      in_wr = 1'b0;
      expv[2] = 8'h5A;
      rd1(3'd2, b1);
      chk(nstb - s0 == 1, "R4 extra clocks no strobe", nstb - s0, 1);
      chk(b1 == 8'h5A, "R4 extra clocks ignored", b1, 8'h5A);

      // burst write (R6 R8)
      s0 = nstb;
      in_wr = 1'b1;
      start_x(); tx(8'hBE);
      for (int i = 0; i < 8; i++) tx((i == 7) ? 8'h80 : 8'((i * 29 + 3) & 255));
      stop_x();
      in_wr = 1'b0;
      for (int i = 0; i < 7; i++) expv[i] = 8'((i * 29 + 3) & 255);
      chk(nstb - s0 == 7, "R8 burst writes seven", nstb - s0, 7);
      rd1(3'd7, b1);
      chk(b1 == 8'h00, "R8 lock register unchanged", b1, 0);

      // burst read (R6)
      start_x(); tx(8'hBF);
      for (int i = 0; i < 8; i++) begin
         rx(b1, oe1);
         chk(b1 == expv[i], "R6 burst read order", b1, expv[i]);
      end
      stop_x();

      // write lock (R7)
      s0 = nstb;
      wr1(3'd7, 8'h80);
      rd1(3'd7, b1);
      chk(b1 == 8'h80 && nstb - s0 == 1, "R7 lock set", b1, 8'h80);
      s0 = nstb;
      wr1(3'd3, 8'h33);
      rd1(3'd3, b1);
      chk(nstb == s0, "R7 locked no strobe", nstb - s0, 0);
      chk(b1 == expv[3], "R7 locked value kept", b1, expv[3]);
      s0 = nstb;
      in_wr = 1'b1;
      start_x(); tx(8'hBE);
      for (int i = 0; i < 8; i++) tx(8'hC3);
      stop_x();
      in_wr = 1'b0;
      chk(nstb == s0, "R7 locked burst no strobe", nstb - s0, 0);
      wr1(3'd7, 8'h00);
      rd1(3'd7, b1);
      chk(b1 == 8'h00, "R7 unlock accepted", b1, 0);

      // reserved test code (R9)
      s0 = nstb;
      start_x(); tx(8'h93); rx(b1, oe1); tx(8'hAA); stop_x();
      chk(!oe1 && nstb == s0, "R9 test code no-op", {oe1, 8'(nstb - s0)}, 0);

      // bit 7 clear (R2)
      s0 = nstb;
      in_wr = 1'b1;
      start_x(); tx(8'h04); tx(8'hAA); stop_x();
      in_wr = 1'b0;
      rd1(3'd2, b1);
      chk(nstb == s0 && b1 == expv[2], "R2 bit7 clear write ignored", b1, expv[2]);
      start_x(); tx(8'h05); rx(b1, oe1); stop_x();
      chk(!oe1, "R2 bit7 clear read no drive", oe1, 0);

      // abort (R10)
      s0 = nstb;
      in_wr = 1'b1;
      start_x(); tx(8'h86);
      for (int i = 0; i < 5; i++) tbit(1'b1, oe1, oe2);
      stop_x();
      in_wr = 1'b0;
      chk(nstb == s0 && !sdo_oe_o, "R10 aborted byte dropped", nstb - s0, 0);
      rd1(3'd3, b1);
      chk(b1 == expv[3], "R10 register kept", b1, expv[3]);
      wr1(3'd3, 8'h6C);
      rd1(3'd3, b1);
      chk(b1 == 8'h6C, "R10 next transfer works", b1, 8'h6C);

      chk(oe_bad == 0, "R11 no drive in writes", oe_bad, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule